// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit processor core that fetches, decodes, executes and retires one instruction per clock cycle. It runs nine instructions: word load, word store, four register-to-register arithmetic and logic operations, signed set-less-than, branch-if-equal and an absolute jump. Every functional unit serves one instruction once per cycle. The incrementer for the sequential PC, the adder for branch targets and the ALU are therefore three separate pieces of hardware. Instruction classes share hardware only through multiplexors: one picks the destination register, one the second ALU operand, one the write-back value and one the next PC.

Instruction and data storage are small word arrays inside the core. A load port fills them while the core is held in reset. Each retired instruction is visible at the ports: the current PC, the register write-back bus (enable, register number, value) and the data-store bus (enable, byte address, data).

Top module: `sc_core`

## Requirements
- R1: While rst_n is low at a rising edge, the PC becomes 0; the first instruction after reset release is fetched from word 0.
- R2: With opcode 0 (bits 31:26), funct (bits 5:0) 0x20/0x22/0x24/0x25/0x2A writes rd (bits 15:11) with rs+rt, rs-rt, rs&rt, rs|rt, or 1/0 for signed rs<rt; rs is bits 25:21, rt bits 20:16.
- R3: Opcode 35 writes rt with the data word at byte address rs + sign-extended bits 15:0.
- R4: Opcode 43 stores rt to the data word at byte address rs + sign-extended bits 15:0 and writes no register.
- R5: Opcode 4 sets the next PC to PC+4 + (sign-extended bits 15:0 shifted left 2) when rs equals rt, and to PC+4 otherwise; it writes nothing.
- R6: Opcode 2 sets the next PC to {PC+4 bits 31:28, instruction bits 25:0, 2'b00}.
- R7: Register 0 reads as zero; a write-back addressed to it leaves it zero.
- R8: Any other opcode, or opcode 0 with any other funct, writes neither a register nor memory and advances the PC by 4.
- R9: An instruction that reads and writes the same register uses the value from before its own edge.
- R10: With ld_en high, ld_data is stored at the next edge into word ld_addr of data memory (ld_dmem=1) or instruction memory (ld_dmem=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_en | input | 1 | Load-port write enable |
| ld_dmem | input | 1 | Load target: 1 data memory, 0 instruction memory |
| ld_addr | input | MEM_AW | Word index written by the load port |
| ld_data | input | XLEN | Word written by the load port |
| pc_o | output | XLEN | Address of the instruction now executing |
| wb_en_o | output | 1 | Register write-back active this cycle |
| wb_reg_o | output | 5 | Register number written back |
| wb_data_o | output | XLEN | Value written back |
| dmem_we_o | output | 1 | Data store active this cycle |
| dmem_addr_o | output | XLEN | Byte address computed by the ALU |
| dmem_wdata_o | output | XLEN | Data stored |

## Verification
Register read and register write for the same register fall into one cycle when an instruction names a register as both source and destination. The bench provokes this with an add that doubles a register in place, and with an add whose destination is register 0. A behavioural reference model predicts write-back value, store bus and next PC every cycle. It also checks that a later reader sees the new value, or zero for register 0. Branch decision and target arithmetic are judged the same way, with taken, not-taken and backward branches and a jump over skipped code.

// File: rtl/sc_core_pkg.sv
// Shared encodings and the control bundle of the single-cycle core.
// Assumes 32-bit instruction words with the opcode in bits 31:26.
package sc_core_pkg;
    localparam logic [5:0] OP_RTYPE = 6'd0;
    localparam logic [5:0] OP_JUMP  = 6'd2;
    localparam logic [5:0] OP_BEQ   = 6'd4;
    localparam logic [5:0] OP_LOAD  = 6'd35;
    localparam logic [5:0] OP_STORE = 6'd43;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [2:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } alu_fn_e;

    typedef enum logic [1:0] {
        AOP_ADD   = 2'b00,
        AOP_SUB   = 2'b01,
        AOP_FUNCT = 2'b10
    } alu_op_e;

    typedef struct packed {
        logic    dst_rd;
        logic    reg_wr;
        logic    src_imm;
        logic    mem_rd;
        logic    mem_wr;
        logic    wb_mem;
        logic    branch;
        logic    jump;
        alu_fn_e alu_fn;
    } ctrl_t;
endpackage

// File: rtl/sc_ctrl.sv
// Main decoder plus ALU function decoder.
// Assumes: unknown opcodes and unknown R-type functs become no-ops.
module sc_ctrl
    import sc_core_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);
    alu_op_e aop;
    logic    main_wr;
    logic    funct_ok;
    alu_fn_e fn_dec;

    // Main decode: opcode to datapath steering.
    always_comb begin
        ctrl    = '0;
        ctrl.alu_fn = ALU_ADD;
        aop     = AOP_ADD;
        main_wr = 1'b0;
        unique case (opcode)
            OP_RTYPE: begin
                ctrl.dst_rd = 1'b1;
                main_wr     = 1'b1;
                aop         = AOP_FUNCT;
            end
            OP_LOAD: begin
                ctrl.src_imm = 1'b1;
                ctrl.mem_rd  = 1'b1;
                ctrl.wb_mem  = 1'b1;
                main_wr      = 1'b1;
            end
            OP_STORE: begin
                ctrl.src_imm = 1'b1;
                ctrl.mem_wr  = 1'b1;
            end
            OP_BEQ: begin
                ctrl.branch = 1'b1;
                aop         = AOP_SUB;
            end
            OP_JUMP: ctrl.jump = 1'b1;
            default: ;
        endcase
        ctrl.alu_fn = (aop == AOP_FUNCT) ? fn_dec :
                      (aop == AOP_SUB)   ? ALU_SUB : ALU_ADD;
        ctrl.reg_wr = main_wr && ((aop != AOP_FUNCT) || funct_ok);
    end

    // Function field decode for register-register operations.
    always_comb begin
        funct_ok = 1'b1;
        fn_dec   = ALU_ADD;
        unique case (funct)
            FN_ADD:  fn_dec = ALU_ADD;
            FN_SUB:  fn_dec = ALU_SUB;
            FN_AND:  fn_dec = ALU_AND;
            FN_OR:   fn_dec = ALU_OR;
            FN_SLT:  fn_dec = ALU_SLT;
            default: funct_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/sc_regfile.sv
// Two-read, one-write register file. Reads are combinational; the write
// lands on the rising edge. Entry 0 reads as zero and is never written.
module sc_regfile #(
    parameter int NREGS = 32,
    parameter int W     = 32
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(NREGS)-1:0] waddr,
    input  logic [W-1:0]             wdata,
    input  logic [$clog2(NREGS)-1:0] raddr_a,
    input  logic [$clog2(NREGS)-1:0] raddr_b,
    output logic [W-1:0]             rdata_a,
    output logic [W-1:0]             rdata_b
);
    localparam int AW = $clog2(NREGS);

    logic [W-1:0] regs [NREGS];

    // Edge write, skipping the hard-wired zero entry.
    always_ff @(posedge clk) begin
        if (we && (waddr != AW'(0))) regs[waddr] <= wdata;
    end

    // Combinational reads with entry 0 forced to zero.
    always_comb begin
        rdata_a = (raddr_a == AW'(0)) ? '0 : regs[raddr_a];
        rdata_b = (raddr_b == AW'(0)) ? '0 : regs[raddr_b];
    end
endmodule

// File: rtl/sc_alu.sv
// Five-function ALU with a zero flag used for the equality branch.
module sc_alu
    import sc_core_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_fn_e      fn,
    output logic [W-1:0] y,
    output logic         zero
);
    // Operation select.
    always_comb begin
        unique case (fn)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);
endmodule

// File: rtl/sc_core.sv
// Single-cycle core: one instruction retires per rising edge.
// Assumes aligned word accesses; memories are indexed by address bits
// [MEM_AW+1:2]. Load port writes memories; reset gates core writes.
module sc_core
    import sc_core_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int MEM_AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic              ld_dmem,
    input  logic [MEM_AW-1:0] ld_addr,
    input  logic [XLEN-1:0]   ld_data,
    output logic [XLEN-1:0]   pc_o,
    output logic              wb_en_o,
    output logic [4:0]        wb_reg_o,
    output logic [XLEN-1:0]   wb_data_o,
    output logic              dmem_we_o,
    output logic [XLEN-1:0]   dmem_addr_o,
    output logic [XLEN-1:0]   dmem_wdata_o
);
    localparam int WORDS  = 1 << MEM_AW;
    localparam int NREGS  = 32;

    logic [31:0]     imem [WORDS];
    logic [XLEN-1:0] dmem [WORDS];

    logic [XLEN-1:0] pc_q, pc_plus4, br_target, jmp_target, pc_next;
    logic [31:0]     instr;
    logic [XLEN-1:0] imm_ext, rs_val, rt_val, alu_b, alu_y, mem_rdata, wb_val;
    logic [4:0]      dst_reg;
    logic            alu_zero, rf_we, dm_we, take_br;
    ctrl_t           ctrl;

    // Fetch from instruction memory at the current PC.
    assign instr = imem[pc_q[MEM_AW+1:2]];

    sc_ctrl u_ctrl (
        .opcode (instr[31:26]),
        .funct  (instr[5:0]),
        .ctrl   (ctrl)
    );

    // Destination select: rd for register ops, rt for loads.
    assign dst_reg = ctrl.dst_rd ? instr[15:11] : instr[20:16];
    assign imm_ext = {{(XLEN-16){instr[15]}}, instr[15:0]};
    assign rf_we   = ctrl.reg_wr && rst_n;
    assign dm_we   = ctrl.mem_wr && rst_n;

    sc_regfile #(.NREGS(NREGS), .W(XLEN)) u_rf (
        .clk     (clk),
        .we      (rf_we),
        .waddr   (dst_reg),
        .wdata   (wb_val),
        .raddr_a (instr[25:21]),
        .raddr_b (instr[20:16]),
        .rdata_a (rs_val),
        .rdata_b (rt_val)
    );

    // Second operand: register or sign-extended offset.
    assign alu_b = ctrl.src_imm ? imm_ext : rt_val;

    sc_alu #(.W(XLEN)) u_alu (
        .a    (rs_val),
        .b    (alu_b),
        .fn   (ctrl.alu_fn),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // Data read and write-back source.
    assign mem_rdata = ctrl.mem_rd ? dmem[alu_y[MEM_AW+1:2]] : '0;
    assign wb_val    = ctrl.wb_mem ? mem_rdata : alu_y;

    // Dedicated adders for sequential and branch targets.
    assign pc_plus4   = pc_q + XLEN'(4);
    assign br_target  = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
    assign jmp_target = {pc_plus4[XLEN-1:28], instr[25:0], 2'b00};
    assign take_br    = ctrl.branch && alu_zero;
    assign pc_next    = ctrl.jump ? jmp_target : (take_br ? br_target : pc_plus4);

    // PC register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_next;
    end

    // Instruction memory fill through the load port.
    always_ff @(posedge clk) begin
        if (ld_en && !ld_dmem) imem[ld_addr] <= ld_data;
    end

    // Data memory: load port first, then core stores.
    always_ff @(posedge clk) begin
        if (ld_en && ld_dmem) dmem[ld_addr] <= ld_data;
        else if (dm_we)       dmem[alu_y[MEM_AW+1:2]] <= rt_val;
    end

    assign pc_o         = pc_q;
    assign wb_en_o      = rf_we;
    assign wb_reg_o     = dst_reg;
    assign wb_data_o    = wb_val;
    assign dmem_we_o    = dm_we;
    assign dmem_addr_o  = alu_y;
    assign dmem_wdata_o = rt_val;
endmodule

// File: rtl/sc_core_chk.sv
// Property checker for sc_core, attached by bind below.
module sc_core_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [XLEN-1:0] pc,
    input logic [31:0]     instr,
    input logic [XLEN-1:0] rs_val,
    input logic [XLEN-1:0] rt_val,
    input logic            wb_en,
    input logic            dm_we
);
    logic [5:0]      op;
    logic [XLEN-1:0] br_tgt, j_tgt, seq_pc;
    logic            known_op;

    assign op       = instr[31:26];
    assign seq_pc   = pc + XLEN'(4);
    assign br_tgt   = seq_pc + {{(XLEN-18){instr[15]}}, instr[15:0], 2'b00};
    assign j_tgt    = {seq_pc[XLEN-1:28], instr[25:0], 2'b00};
    assign known_op = (op == 6'd0) || (op == 6'd2) || (op == 6'd4) ||
                      (op == 6'd35) || (op == 6'd43);

    assert_reset_pc_R1: assert property (@(posedge clk)
        !rst_n |=> (pc == '0));

    assert_wb_class_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> ((op == 6'd0) || (op == 6'd35)));

    assert_store_no_wb_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dm_we |-> !wb_en);

    assert_beq_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((op == 6'd4) && (rs_val == rt_val)) |=> (pc == $past(br_tgt)));

    assert_jump_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 6'd2) |=> (pc == $past(j_tgt)));

    assert_seq_pc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((op != 6'd2) && (op != 6'd4)) |=> (pc == $past(seq_pc)));

    assert_bad_op_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !known_op |-> (!wb_en && !dm_we));
endmodule

bind sc_core sc_core_chk #(.XLEN(XLEN)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .pc     (pc_q),
    .instr  (instr),
    .rs_val (rs_val),
    .rt_val (rt_val),
    .wb_en  (rf_we),
    .dm_we  (dm_we)
);

// File: tb/sc_core_tb.sv
// Self-checking bench: behavioural reference interpreter compared each cycle.
module sc_core_tb;
    localparam int XLEN   = 32;
    localparam int MEM_AW = 6;
    localparam int WORDS  = 1 << MEM_AW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ld_en = 1'b0;
    logic              ld_dmem = 1'b0;
    logic [MEM_AW-1:0] ld_addr = '0;
    logic [XLEN-1:0]   ld_data = '0;
    logic [XLEN-1:0]   pc_o, wb_data_o, dmem_addr_o, dmem_wdata_o;
    logic              wb_en_o, dmem_we_o;
    logic [4:0]        wb_reg_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    sc_core #(.XLEN(XLEN), .MEM_AW(MEM_AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_dmem(ld_dmem),
        .ld_addr(ld_addr), .ld_data(ld_data), .pc_o(pc_o),
        .wb_en_o(wb_en_o), .wb_reg_o(wb_reg_o), .wb_data_o(wb_data_o),
        .dmem_we_o(dmem_we_o), .dmem_addr_o(dmem_addr_o),
        .dmem_wdata_o(dmem_wdata_o)
    );

    // Reference state.
    logic [31:0] m_imem [WORDS];
    logic [31:0] m_dmem [WORDS];
    logic [31:0] m_regs [32];
    logic [31:0] m_pc;

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction
    function automatic logic [31:0] enc_j(int word);
        return {6'd2, 26'(word)};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s pc=%h actual=%h expected=%h", tag, m_pc, act, exp);
        end
    endtask

    // Compare one cycle against the model, then advance the model.
    task automatic step_and_check();
        logic [31:0] ins, a, b, se, res, addr, npc;
        logic [5:0]  op, fn;
        int rs, rt, rd;
        logic e_wb, e_we;
        int   e_reg;
        string tag;
        ins = m_imem[m_pc[MEM_AW+1:2]];
        op = ins[31:26]; fn = ins[5:0];
        rs = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]);
        a = m_regs[rs]; b = m_regs[rt];
        se = {{16{ins[15]}}, ins[15:0]};
        npc = m_pc + 4; e_wb = 0; e_we = 0; e_reg = 0; res = 0; addr = 0;
        tag = "R8";
        case (op)
            6'd0: begin
                e_wb = 1; e_reg = rd; tag = "R2";
                case (fn)
                    6'h20: res = a + b;
                    6'h22: res = a - b;
                    6'h24: res = a & b;
                    6'h25: res = a | b;
                    6'h2A: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
                    default: begin e_wb = 0; tag = "R8"; end
                endcase
                if (e_wb && rd == 0) tag = "R7";
                else if (e_wb && (rd == rs || rd == rt)) tag = "R9";
            end
            6'd35: begin
                addr = a + se; res = m_dmem[addr[MEM_AW+1:2]];
                e_wb = 1; e_reg = rt; tag = "R3 R10";
            end
            6'd43: begin addr = a + se; e_we = 1; tag = "R4"; end
            6'd4: begin
                tag = "R5";
                if (a == b) npc = m_pc + 4 + (se << 2);
            end
            6'd2: begin
                tag = "R6";
                npc = {m_pc[31:28] + 4'((m_pc + 4) >> 28) - m_pc[31:28], ins[25:0], 2'b00};
            end
            default: ;
        endcase
        if (rs == 0 && e_wb && op == 6'd0 && tag == "R2") tag = "R7";
        check(tag, pc_o, m_pc);
        check(tag, {31'd0, wb_en_o}, {31'd0, e_wb});
        if (e_wb) begin
            check(tag, {27'd0, wb_reg_o}, 32'(e_reg));
            check(tag, wb_data_o, res);
        end
        check(tag, {31'd0, dmem_we_o}, {31'd0, e_we});
        if (e_we) begin
            check(tag, dmem_addr_o, addr);
            check(tag, dmem_wdata_o, b);
        end
        if (e_wb && e_reg != 0) m_regs[e_reg] = res;
        if (e_we) m_dmem[addr[MEM_AW+1:2]] = b;
        m_pc = npc;
    endtask

    task automatic load_word(bit to_d, int idx, logic [31:0] val);
        @(negedge clk);
        ld_en = 1; ld_dmem = to_d; ld_addr = MEM_AW'(idx); ld_data = val;
        if (to_d) m_dmem[idx] = val; else m_imem[idx] = val;
    endtask

    initial begin
        for (int i = 0; i < WORDS; i++) begin m_imem[i] = 32'hFC00_0000; m_dmem[i] = 0; end
        for (int i = 0; i < 32; i++) m_regs[i] = 0;
        m_pc = 0;
        // Program.
        m_imem[0]  = enc_i(6'd35, 0, 1, 0);        // lw $1,0($0)
        m_imem[1]  = enc_i(6'd35, 0, 2, 4);        // lw $2,4($0)
        m_imem[2]  = enc_r(1, 2, 3, 6'h20);        // add
        m_imem[3]  = enc_r(1, 2, 4, 6'h22);        // sub
        m_imem[4]  = enc_r(1, 2, 5, 6'h24);        // and
        m_imem[5]  = enc_r(1, 2, 6, 6'h25);        // or
        m_imem[6]  = enc_r(2, 1, 7, 6'h2A);        // slt negative < positive
        m_imem[7]  = enc_r(1, 2, 8, 6'h2A);        // slt false
        m_imem[8]  = enc_r(1, 1, 0, 6'h20);        // write to $0
        m_imem[9]  = enc_r(0, 1, 9, 6'h20);        // read $0
        m_imem[10] = enc_r(1, 1, 1, 6'h20);        // in-place double
        m_imem[11] = enc_i(6'd43, 0, 1, 8);        // sw $1,8($0)
        m_imem[12] = enc_i(6'd35, 0, 10, 8);       // lw $10,8($0)
        m_imem[13] = enc_i(6'd35, 4, 12, -4);      // lw negative offset
        m_imem[14] = enc_i(6'd4, 1, 10, 1);        // beq taken
        m_imem[15] = enc_r(1, 1, 13, 6'h20);       // skipped
        m_imem[16] = enc_i(6'd4, 1, 2, 5);         // beq not taken
        m_imem[17] = 32'hFC21_0000;                // unknown opcode
        m_imem[18] = enc_r(1, 1, 14, 6'h3F);       // unknown funct
        m_imem[19] = enc_j(22);                    // jump
        m_imem[20] = enc_r(1, 1, 15, 6'h20);       // skipped
        m_imem[21] = enc_r(1, 1, 16, 6'h20);       // skipped
        m_imem[22] = enc_i(6'd4, 0, 0, -1);        // backward self-branch
        // Fill DUT through the load port under reset (R10).
        for (int i = 0; i < 24; i++) load_word(0, i, m_imem[i]);
        for (int i = 24; i < WORDS; i++) load_word(0, i, m_imem[i]);
        load_word(1, 0, 32'd5);
        load_word(1, 1, 32'hFFFF_FFFD);
        for (int i = 2; i < WORDS; i++) load_word(1, i, 32'd0);
        @(negedge clk); ld_en = 0;
        @(negedge clk);
        // Reset state (R1).
        check("R1", pc_o, 32'd0);
        check("R1", {31'd0, wb_en_o}, 32'd0);
        check("R1", {31'd0, dmem_we_o}, 32'd0);
        @(negedge clk);
        rst_n = 1;
        for (int c = 0; c < 40; c++) begin
            #1;
            step_and_check();
            @(negedge clk);
        end
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Watchdog.
    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog R1 actual=%h expected=%h", pc_o, 32'd0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule